// File: doc/BRIEF.md
# Configuration Image Burst Loader

This block loads a partial configuration image from external memory into an internal 32-bit configuration port without processor help once it has been launched. Software sets two values through a small register slave (the byte address where the image starts and its length in 32-bit words) and then writes a start command. From that point the block reads the image on its own.

A fetch engine reads memory as fixed-length bursts on a 64-bit request/grant read port. It writes each 64-bit beat into an internal FIFO, and it asks for another burst only when the FIFO can take a whole burst. A drain stage takes entries out of the FIFO whenever it holds data, splits each one into two 32-bit words and puts one word on the configuration port per clock. Once the last word has been presented, the block clears its busy bit and raises a sticky completion flag, which is also driven on a pin.

Top module: `cfg_dma_top`

## Requirements
- R1: Register slave, where an offset is decoded from `reg_addr`. Offset 0x0 holds the image start byte address and offset 0x4 holds the image size in 32-bit words. Both read back what was written. A write to offset 0x8 with bit 0 set is a start command. Offset 0xC is status: bit 0 busy, bit 1 done, bit 2 error.
- R2: A start command accepted while idle, with an even non-zero size, sets busy and clears done and error. The whole image is then fetched with no further register access. `cfg_valid` is high only while busy is set.
- R3: Each memory request asks for 32 beats of 64 bits, except the last one, which asks for the beats that remain. Request addresses start at the programmed address and advance by 256 bytes from one request to the next. A pending request holds its address and length stable until `mem_gnt`.
- R4: Every 64-bit beat becomes two configuration words. Bits 31:0 come out first and bits 63:32 come out on the next cycle. Words leave in ascending memory address order, one per cycle on which `cfg_valid` is high.
- R5: A burst is requested only while the FIFO has at least 32 free entries. No returned beat is ever lost, even when memory returns data faster than the port drains it.
- R6: When memory returns one beat per cycle, `cfg_valid` stays high on every cycle from the first word of a transfer to its last word.
- R7: On the cycle after the last word is presented, busy reads 0 and done reads 1, and `dma_done` follows the done bit. Done stays set until 1 is written to status bit 1.
- R8: A start command with an odd or zero size sets the error bit and leaves busy at 0. It issues no memory request and no configuration word. Writing 1 to status bit 2 clears the error bit.
- R9: A start command written while busy is ignored. The transfer in progress finishes with its original address and size, no extra words appear, and the error bit is not set.
- R10: After reset, status reads 0, and `mem_req`, `cfg_valid` and `dma_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by every part of the block |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 4 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| dma_done | output | 1 | Completion flag, a copy of status done |
| mem_req | output | 1 | Burst read request, held until granted |
| mem_addr | output | 32 | Byte address of the burst |
| mem_beats | output | 6 | Number of 64-bit beats in the burst |
| mem_gnt | input | 1 | One-cycle grant of the pending request |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | 64 | Read beat data |
| cfg_valid | output | 1 | Configuration word valid |
| cfg_data | output | 32 | Configuration word |

## Verification
The bench checks the following cases:
- A 150-word image ends in an 11-beat burst. A loader that did not shorten its last burst would log a 32-beat request and stream stale words.
- A 1024-word image is read from a memory that returns data every cycle. If the loader ignored the free-space rule it would overrun its FIFO, and the scoreboard would see words missing or out of order. A drain that stalled would open gaps in the stream.
- Start commands are sent with an odd size, with a zero size and while a transfer is running. Any of them being honoured would show up as unexpected words, bursts or error bits.
- Words are checked for half order and address order, and done is checked on the exact cycle after the last word.

// File: rtl/cfg_dma_pkg.sv
// Shared constants for the configuration image loader.
// Assumes a 4-bit byte offset register slave with 32-bit data.
package cfg_dma_pkg;
    localparam logic [3:0] OFS_BASE = 4'h0;
    localparam logic [3:0] OFS_SIZE = 4'h4;
    localparam logic [3:0] OFS_CTRL = 4'h8;
    localparam logic [3:0] OFS_STAT = 4'hC;

    localparam int ST_BUSY = 0;
    localparam int ST_DONE = 1;
    localparam int ST_ERR  = 2;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_REQ  = 2'd1,
        FS_DATA = 2'd2
    } fetch_state_t;
endpackage

// File: rtl/cfg_dma_regs.sv
// Register slave and job control. Validates the start command, launches the
// fetch engine, counts delivered words and raises the sticky completion flag.
// Assumes size is in 32-bit words and that word_sent pulses once per word.
module cfg_dma_regs
    import cfg_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 20,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              word_sent,
    output logic              go,
    output logic [ADDR_W-1:0] go_addr,
    output logic [LEN_W-1:0]  go_beats,
    output logic              busy,
    output logic              done
);
    logic [ADDR_W-1:0] base_q;
    logic [DATA_W-1:0] size_q;
    logic [DATA_W-1:0] left_q;
    logic              busy_q, done_q, err_q;
    logic              start_wr, size_ok;

    assign start_wr = reg_wr && (reg_addr == OFS_CTRL) && reg_wdata[0];
    assign size_ok  = (size_q[DATA_W-1:LEN_W+1] == '0) && (size_q != '0) && !size_q[0];
    assign go       = start_wr && !busy_q && size_ok;
    assign go_addr  = base_q;
    assign go_beats = size_q[LEN_W:1];
    assign busy     = busy_q;
    assign done     = done_q;

    // Holds the programmed image address and size.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            size_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == OFS_BASE) base_q <= reg_wdata[ADDR_W-1:0];
            if (reg_addr == OFS_SIZE) size_q <= reg_wdata;
        end
    end

    // Tracks busy, done and error, and counts the words still to deliver.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            left_q <= '0;
        end else if (go) begin
            busy_q <= 1'b1;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            left_q <= size_q;
        end else begin
            if (start_wr && !busy_q) err_q <= 1'b1;
            if (reg_wr && reg_addr == OFS_STAT) begin
                if (reg_wdata[ST_DONE]) done_q <= 1'b0;
                if (reg_wdata[ST_ERR])  err_q  <= 1'b0;
            end
            if (busy_q && word_sent) begin
                left_q <= left_q - DATA_W'(1);
                if (left_q == DATA_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    // Returns the register selected by the offset.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_BASE: reg_rdata[ADDR_W-1:0] = base_q;
            OFS_SIZE: reg_rdata = size_q;
            OFS_STAT: begin
                reg_rdata[ST_BUSY] = busy_q;
                reg_rdata[ST_DONE] = done_q;
                reg_rdata[ST_ERR]  = err_q;
            end
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cfg_dma_fifo.sv
// Show-ahead synchronous FIFO between the fetch engine and the drain stage.
// Assumes DEPTH is a power of two, that push never happens when full and
// that pop never happens when empty.
module cfg_dma_fifo #(
    parameter int WIDTH = 64,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full,
    output logic [CW-1:0]    count
);
    logic [WIDTH-1:0] store [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    cnt_q;

    assign rd_data = store[rd_ptr];
    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign count   = cnt_q;

    // Writes incoming beats into storage.
    always_ff @(posedge clk) begin
        if (push) store[wr_ptr] <= push_data;
    end

    // Moves the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/cfg_dma_fetch.sv
// Burst read master. Splits a job into requests of BURST beats, with the last
// one shortened. A request is raised only when the FIFO can take a whole
// burst. Assumes one burst in flight, all of its beats returned after the
// grant, and no backpressure on returned beats.
module cfg_dma_fetch
    import cfg_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 20,
    parameter int MEM_W  = 64,
    parameter int BURST  = 32,
    parameter int DEPTH  = 64,
    localparam int CNT_W = $clog2(DEPTH) + 1,
    localparam int BL_W  = $clog2(BURST + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] go_addr,
    input  logic [LEN_W-1:0]  go_beats,
    input  logic [CNT_W-1:0]  fifo_count,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BL_W-1:0]   mem_beats,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    output logic              push
);
    localparam int BEAT_SH = $clog2(MEM_W / 8);
    localparam logic [LEN_W-1:0] BURST_L  = LEN_W'(BURST);
    localparam logic [CNT_W-1:0] ROOM_MAX = CNT_W'(DEPTH - BURST);

    fetch_state_t      state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  left_q;
    logic [BL_W-1:0]   len_q, beat_q;
    logic              room;

    assign room      = (fifo_count <= ROOM_MAX);
    assign mem_req   = (state_q == FS_REQ);
    assign mem_addr  = addr_q;
    assign mem_beats = len_q;
    assign push      = (state_q == FS_DATA) && mem_rvalid;

    // Sequences the request, the grant and the beat collection of each burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
            addr_q  <= '0;
            left_q  <= '0;
            len_q   <= '0;
            beat_q  <= '0;
        end else begin
            case (state_q)
                FS_IDLE: begin
                    if (go) begin
                        addr_q <= go_addr;
                        left_q <= go_beats;
                    end else if (left_q != '0 && room) begin
                        len_q   <= (left_q > BURST_L) ? BL_W'(BURST) : BL_W'(left_q);
                        state_q <= FS_REQ;
                    end
                end
                FS_REQ: begin
                    if (mem_gnt) begin
                        beat_q  <= len_q;
                        addr_q  <= addr_q + (ADDR_W'(len_q) << BEAT_SH);
                        left_q  <= left_q - LEN_W'(len_q);
                        state_q <= FS_DATA;
                    end
                end
                FS_DATA: begin
                    if (mem_rvalid) begin
                        beat_q <= beat_q - 1'b1;
                        if (beat_q == BL_W'(1)) state_q <= FS_IDLE;
                    end
                end
                default: state_q <= FS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cfg_dma_drain.sv
// Drain stage. Takes a FIFO entry whenever one is present and no upper half
// is waiting, then sends the lower half and the upper half on consecutive
// cycles. Assumes MEM_W is exactly twice PORT_W.
module cfg_dma_drain #(
    parameter int MEM_W  = 64,
    parameter int PORT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_empty,
    input  logic [MEM_W-1:0]  fifo_data,
    output logic              pop,
    output logic              cfg_valid,
    output logic [PORT_W-1:0] cfg_data
);
    logic [PORT_W-1:0] hi_q;
    logic              have_hi;

    assign pop = !have_hi && !fifo_empty;

    // Registers one word per cycle, lower half first, then the held upper half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q      <= '0;
            have_hi   <= 1'b0;
            cfg_valid <= 1'b0;
            cfg_data  <= '0;
        end else if (have_hi) begin
            cfg_data  <= hi_q;
            cfg_valid <= 1'b1;
            have_hi   <= 1'b0;
        end else if (pop) begin
            cfg_data  <= fifo_data[PORT_W-1:0];
            hi_q      <= fifo_data[MEM_W-1:PORT_W];
            cfg_valid <= 1'b1;
            have_hi   <= 1'b1;
        end else begin
            cfg_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/cfg_dma_top.sv
// Configuration image loader top. Connects the register slave, the burst
// fetch engine, the beat FIFO and the drain stage. Everything runs on one clock.
module cfg_dma_top #(
    parameter int ADDR_W      = 32,
    parameter int LEN_W       = 20,
    parameter int MEM_W       = 64,
    parameter int PORT_W      = 32,
    parameter int BURST_BEATS = 32,
    parameter int FIFO_DEPTH  = 64,
    localparam int CNT_W      = $clog2(FIFO_DEPTH) + 1,
    localparam int BL_W       = $clog2(BURST_BEATS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              dma_done,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BL_W-1:0]   mem_beats,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [MEM_W-1:0]  mem_rdata,
    output logic              cfg_valid,
    output logic [PORT_W-1:0] cfg_data
);
    logic              go, busy, done;
    logic [ADDR_W-1:0] go_addr;
    logic [LEN_W-1:0]  go_beats;
    logic              fifo_push, fifo_pop, fifo_empty, fifo_full;
    logic [MEM_W-1:0]  fifo_rdata;
    logic [CNT_W-1:0]  fifo_cnt;

    // Stops elaboration on parameter sets the datapath cannot handle.
    if (MEM_W != 2 * PORT_W) begin : g_bad_ratio
        $error("memory width must be twice the port width");
    end
    if (FIFO_DEPTH < BURST_BEATS) begin : g_bad_depth
        $error("FIFO must hold at least one burst");
    end

    assign dma_done = done;

    cfg_dma_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(32)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .word_sent(cfg_valid),
        .go(go), .go_addr(go_addr), .go_beats(go_beats), .busy(busy), .done(done)
    );

    cfg_dma_fetch #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MEM_W(MEM_W),
                    .BURST(BURST_BEATS), .DEPTH(FIFO_DEPTH)) u_fetch (
        .clk(clk), .rst_n(rst_n), .go(go), .go_addr(go_addr), .go_beats(go_beats),
        .fifo_count(fifo_cnt), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_beats(mem_beats), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .push(fifo_push)
    );

    cfg_dma_fifo #(.WIDTH(MEM_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(fifo_push), .push_data(mem_rdata),
        .pop(fifo_pop), .rd_data(fifo_rdata), .empty(fifo_empty),
        .full(fifo_full), .count(fifo_cnt)
    );

    cfg_dma_drain #(.MEM_W(MEM_W), .PORT_W(PORT_W)) u_drain (
        .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_data(fifo_rdata),
        .pop(fifo_pop), .cfg_valid(cfg_valid), .cfg_data(cfg_data)
    );
endmodule

// File: rtl/cfg_dma_chk.sv
// Property checker for the configuration image loader, bound to the top.
module cfg_dma_chk #(
    parameter int ADDR_W      = 32,
    parameter int MEM_W       = 64,
    parameter int PORT_W      = 32,
    parameter int BURST_BEATS = 32,
    parameter int FIFO_DEPTH  = 64,
    localparam int CNT_W      = $clog2(FIFO_DEPTH) + 1,
    localparam int BL_W       = $clog2(BURST_BEATS + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_gnt,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [BL_W-1:0]   mem_beats,
    input logic              fifo_push,
    input logic              fifo_full,
    input logic              fifo_pop,
    input logic [MEM_W-1:0]  fifo_rdata,
    input logic [CNT_W-1:0]  fifo_cnt,
    input logic              cfg_valid,
    input logic [PORT_W-1:0] cfg_data,
    input logic              busy,
    input logic              dma_done
);
    localparam logic [CNT_W-1:0] ROOM_MAX = CNT_W'(FIFO_DEPTH - BURST_BEATS);
    localparam logic [BL_W-1:0]  LEN_MAX  = BL_W'(BURST_BEATS);

    // R5: a pending request always has room for a full burst
    p_req_room_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> fifo_cnt <= ROOM_MAX);

    // R5: a beat never lands in a full FIFO
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> !fifo_full);

    // R3: request length lies between one beat and a full burst
    p_burst_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_beats != '0) && (mem_beats <= LEN_MAX));

    // R3: an ungranted request stays up and unchanged
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_beats));

    // R4: the lower half of a popped entry leaves first
    p_low_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> cfg_valid && cfg_data == $past(fifo_rdata[PORT_W-1:0]));

    // R4: the upper half follows on the next cycle
    p_high_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> ##1 (cfg_valid && cfg_data == $past(fifo_rdata[MEM_W-1:PORT_W], 2)));

    // R2: words reach the port only inside a busy job
    p_word_in_job_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> busy);

    // R7: completion and busy never overlap
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dma_done |-> !busy);
endmodule

bind cfg_dma_top cfg_dma_chk #(
    .ADDR_W(ADDR_W), .MEM_W(MEM_W), .PORT_W(PORT_W),
    .BURST_BEATS(BURST_BEATS), .FIFO_DEPTH(FIFO_DEPTH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_gnt(mem_gnt),
    .mem_addr(mem_addr), .mem_beats(mem_beats), .fifo_push(fifo_push),
    .fifo_full(fifo_full), .fifo_pop(fifo_pop), .fifo_rdata(fifo_rdata),
    .fifo_cnt(fifo_cnt), .cfg_valid(cfg_valid), .cfg_data(cfg_data),
    .busy(busy), .dma_done(dma_done)
);

// File: tb/cfg_dma_top_test.sv
// Scoreboard bench: launch tasks queue the expected words, a monitor pops them.
module cfg_dma_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dma_done;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [5:0]  mem_beats;
    logic        mem_gnt = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        cfg_valid;
    logic [31:0] cfg_data;

    int          n_checks = 0;
    int          n_fails  = 0;
    logic [31:0] exp_q[$];
    int          log_addr[$];
    int          log_len[$];
    int          mem_lat  = 0;
    bit          gap_mode = 1'b0;
    bit          started  = 1'b0;
    bit          pend_done = 1'b0;
    int          gap_cnt  = 0;
    int          extra_cnt = 0;

    always #2 clk = ~clk;

    cfg_dma_top uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_done(dma_done),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_beats(mem_beats),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .cfg_valid(cfg_valid), .cfg_data(cfg_data)
    );

    function automatic logic [31:0] word_at(input logic [31:0] a);
        return {~a[15:0], a[15:0]};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic launch(input logic [31:0] base, input int words);
        log_addr.delete();
        log_len.delete();
        gap_cnt = 0;
        reg_write(4'h0, base);
        reg_write(4'h4, words);
        for (int i = 0; i < words; i++) exp_q.push_back(word_at(base + 4 * i));
        reg_write(4'h8, 32'h1);
    endtask

    task automatic wait_done();
        while (!dma_done) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic check_bursts(input logic [31:0] base, input int words, input string tag);
        int beats = words / 2;
        int nb = (beats + 31) / 32;
        check(log_addr.size() == nb, tag, log_addr.size(), nb);
        for (int k = 0; k < nb && k < log_addr.size(); k++) begin
            int el = (beats - 32 * k > 32) ? 32 : beats - 32 * k;
            check(log_addr[k] == int'(base + 256 * k), tag, log_addr[k], base + 256 * k);
            check(log_len[k] == el, tag, log_len[k], el);
        end
    endtask

    // Memory model: grants after mem_lat cycles, then returns the beats.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && mem_req) begin
                logic [31:0] a;
                int n;
                a = mem_addr;
                n = int'(mem_beats);
                log_addr.push_back(a);
                log_len.push_back(n);
                repeat (mem_lat) @(negedge clk);
                mem_gnt = 1'b1;
                @(negedge clk);
                mem_gnt = 1'b0;
                for (int b = 0; b < n; b++) begin
                    if (gap_mode && (b % 3 == 1)) @(negedge clk);
                    mem_rvalid = 1'b1;
                    mem_rdata  = {word_at(a + 8 * b + 4), word_at(a + 8 * b)};
                    @(negedge clk);
                    mem_rvalid = 1'b0;
                end
            end
        end
    end

    // Monitor: compares words, tracks stream gaps and completion timing.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (pend_done) begin
                    check(dma_done == 1'b1, "R7 done after last word", dma_done, 1);
                    pend_done = 1'b0;
                end
                if (cfg_valid) begin
                    if (exp_q.size() == 0) begin
                        extra_cnt++;
                        check(1'b0, "R9 unexpected word", cfg_data, 0);
                    end else begin
                        logic [31:0] e;
                        e = exp_q.pop_front();
                        check(cfg_data == e, "R4 word order", cfg_data, e);
                        started = 1'b1;
                        if (exp_q.size() == 0) begin
                            check(dma_done == 1'b0, "R7 done early", dma_done, 0);
                            pend_done = 1'b1;
                            started = 1'b0;
                        end
                    end
                end else if (started && exp_q.size() > 0) begin
                    gap_cnt++;
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Stimulus.
    initial begin
        logic [31:0] rd;
        repeat (5) @(negedge clk);
        check(cfg_valid == 1'b0, "R10 cfg_valid reset", cfg_valid, 0);
        check(mem_req == 1'b0, "R10 mem_req reset", mem_req, 0);
        rst_n = 1'b1;
        reg_read(4'hC, rd);
        check(rd == 32'h0, "R10 status reset", rd, 0);
        check(dma_done == 1'b0, "R10 dma_done reset", dma_done, 0);

        // R1: register readback
        reg_write(4'h0, 32'h0012_3400);
        reg_write(4'h4, 32'd96);
        reg_read(4'h0, rd);
        check(rd == 32'h0012_3400, "R1 address readback", rd, 32'h0012_3400);
        reg_read(4'h4, rd);
        check(rd == 32'd96, "R1 size readback", rd, 96);

        // R2 R3 R6 R7: two full bursts, memory streaming every cycle
        mem_lat = 0; gap_mode = 1'b0;
        launch(32'h0000_1000, 128);
        reg_read(4'hC, rd);
        check(rd == 32'h1, "R2 busy after start", rd, 1);
        wait_done();
        check_bursts(32'h0000_1000, 128, "R3 burst list");
        check(gap_cnt == 0, "R6 continuous stream", gap_cnt, 0);
        reg_read(4'hC, rd);
        check(rd == 32'h2, "R7 status done", rd, 2);
        repeat (5) @(negedge clk);
        check(dma_done == 1'b1, "R7 done sticky", dma_done, 1);
        reg_write(4'hC, 32'h2);
        reg_read(4'hC, rd);
        check(rd == 32'h0, "R7 done cleared", rd, 0);
        check(dma_done == 1'b0, "R7 dma_done cleared", dma_done, 0);

        // R3: truncated last burst, slow grant and gaps in returned data
        mem_lat = 3; gap_mode = 1'b1;
        launch(32'h0004_0000, 150);
        wait_done();
        check_bursts(32'h0004_0000, 150, "R3 truncated burst");
        check(exp_q.size() == 0, "R4 all words seen", exp_q.size(), 0);

        // R5 R6: long image, memory faster than the port
        mem_lat = 0; gap_mode = 1'b0;
        launch(32'h0010_0000, 1024);
        wait_done();
        check(exp_q.size() == 0, "R5 no lost beats", exp_q.size(), 0);
        check(gap_cnt == 0, "R6 continuous long stream", gap_cnt, 0);
        check_bursts(32'h0010_0000, 1024, "R3 long burst list");
        reg_write(4'hC, 32'h2);

        // R8: odd size and zero size are rejected
        log_addr.delete();
        reg_write(4'h4, 32'd7);
        reg_write(4'h8, 32'h1);
        repeat (40) @(negedge clk);
        reg_read(4'hC, rd);
        check(rd == 32'h4, "R8 odd size error", rd, 4);
        check(log_addr.size() == 0, "R8 no request on odd size", log_addr.size(), 0);
        reg_write(4'hC, 32'h4);
        reg_read(4'hC, rd);
        check(rd == 32'h0, "R8 error cleared", rd, 0);
        reg_write(4'h4, 32'd0);
        reg_write(4'h8, 32'h1);
        repeat (20) @(negedge clk);
        reg_read(4'hC, rd);
        check(rd == 32'h4, "R8 zero size error", rd, 4);
        check(log_addr.size() == 0, "R8 no request on zero size", log_addr.size(), 0);
        reg_write(4'hC, 32'h4);

        // R9: start while busy is ignored
        mem_lat = 2;
        launch(32'h0000_8000, 64);
        reg_write(4'h0, 32'h0000_9000);
        reg_write(4'h4, 32'd32);
        reg_write(4'h8, 32'h1);
        reg_read(4'hC, rd);
        check(rd == 32'h1, "R9 busy, no error", rd, 1);
        wait_done();
        repeat (40) @(negedge clk);
        check(log_addr.size() == 1, "R9 single burst", log_addr.size(), 1);
        if (log_addr.size() > 0)
            check(log_addr[0] == 32'h0000_8000, "R9 original address", log_addr[0], 32'h8000);
        check(extra_cnt == 0, "R9 no extra words", extra_cnt, 0);
        reg_read(4'hC, rd);
        check(rd == 32'h2, "R9 status after job", rd, 2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule